// File: doc/BRIEF.md
# Fatal Error Flood Controller

This block keeps corrupted data from spreading through a system of linked nodes once a serious error has occurred. A node that detects a local fatal error, or that receives the reserved flood control word on any of its incoming links, stops passing its normal outgoing traffic. From then on it drives the flood word on every outgoing link. The flood therefore spreads from node to node until it reaches the bridge at the edge of the system.

The same block carries the terminal function used at the bridge. When a configuration enable is set, the first entry into the flood state raises a system reset request for a fixed number of cycles. Two resets are kept apart. A warm reset clears the flood state and the link detectors. A power-on reset also clears the sticky cause bits. Because those bits survive the warm reset, boot firmware can read whether the flood began locally and on which link it was first seen.

Top module: `flood_guard`

## Requirements
- R1: After a power-on reset, `flooding` is 0, `sys_rst_req` is 0, `cause_local` is 0, `cause_link` is all zero, and each outgoing link carries its `tx_data` word.
- R2: When `local_fatal` is high at a clock edge, `flooding` is 1 after that edge. From then on, every outgoing link carries the all-ones flood word.
- R3: A link is detected as flooding when it carries the all-ones word for FLOOD_RUN consecutive cycles (default 4). `flooding` rises after the edge that samples the last of these words. A run that is shorter and is broken by any other word causes no flood.
- R4: Once set, `flooding` stays at 1 until a warm or power-on reset. Later changes on `local_fatal` or the incoming links have no effect on it or on the outgoing words.
- R5: On the first flood entry after power-on, `cause_local` records whether `local_fatal` caused it. `cause_link` records, one-hot, the lowest-numbered link whose detection caused it (bit i stands for link i). Later flood entries leave both fields unchanged.
- R6: The cause fields keep their values through a warm reset. Only a power-on reset clears them.
- R7: When `cfg_rst_en` is 1, `sys_rst_req` rises one cycle after `flooding` rises. It stays high for exactly RST_HOLD cycles (default 16) and is raised only once per flood episode.
- R8: When `cfg_rst_en` is 0 as the flood begins, `sys_rst_req` stays 0.
- R9: A warm reset clears `flooding` and every partial flood-word run count. Outgoing links then carry `tx_data` again.
- R10: While not flooding, each outgoing link carries its own `tx_data` word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset, clears everything |
| warm_rst_n | input | 1 | Synchronous active-low warm reset, clears flood state but not cause bits |
| local_fatal | input | 1 | Local serious error indication |
| cfg_rst_en | input | 1 | Enables the reset request on flood entry (bridge role) |
| rx_word | input | NUM_LINKS*CW | Incoming control word per link, link i at bits [i*CW +: CW] |
| tx_data | input | NUM_LINKS*CW | Normal outgoing word per link |
| tx_word | output | NUM_LINKS*CW | Word driven on each outgoing link |
| flooding | output | 1 | Node is in the flood state |
| sys_rst_req | output | 1 | System reset request pulse |
| cause_local | output | 1 | Sticky: first flood began from a local error |
| cause_link | output | NUM_LINKS | Sticky one-hot: link on which the first flood was seen |

## Verification
The bench first feeds a run of flood words one short of the threshold, then breaks it. A detector that counts total words instead of consecutive ones would flood there. A threshold that is off by one shows up in the check of the exact cycle `flooding` rises. Run counts left over across a warm reset are tested by splitting a run across that reset. A design whose warm reset missed the detectors would flood early. Further tests cover a reset request one cycle too long or short, cause bits wiped by the warm reset or overwritten by a second flood, a wrong link chosen when two links hit together, and a request raised while the enable is low.

// File: rtl/flood_pkg.sv
// Shared types for the fatal error flood controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package flood_pkg;
    // States of the reset request generator.
    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,
        RQ_HOLD = 2'd1,
        RQ_DONE = 2'd2
    } rq_state_t;
endpackage

// File: rtl/flood_rx_detect.sv
// Watches one incoming link for the reserved all-ones flood word.
// Raises hit combinationally on the FLOOD_RUN-th consecutive flood word.
// Assumes normal traffic never carries the all-ones word for FLOOD_RUN cycles.
module flood_rx_detect #(
    parameter int CW        = 16,
    parameter int FLOOD_RUN = 4
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          warm_rst_n,
    input  logic [CW-1:0] rx_word,
    output logic          hit
);
    localparam int RW = (FLOOD_RUN > 1) ? $clog2(FLOOD_RUN) : 1;
    localparam logic [RW-1:0] LAST = RW'(FLOOD_RUN - 1);

    logic          is_flood;
    logic [RW-1:0] run;

    assign is_flood = (rx_word == {CW{1'b1}});

    // Count consecutive flood words, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!por_n || !warm_rst_n) begin
            run <= '0;
        end else if (is_flood) begin
            run <= (run == LAST) ? run : run + RW'(1);
        end else begin
            run <= '0;
        end
    end

    assign hit = is_flood && (run == LAST);
endmodule

// File: rtl/flood_ctrl.sv
// Holds the flood state and the sticky cause record.
// Flood state is cleared by either reset; causes only by power-on reset.
// Assumes link_hit is already qualified per link.
module flood_ctrl #(
    parameter int NUM_LINKS = 3
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 warm_rst_n,
    input  logic                 local_fatal,
    input  logic [NUM_LINKS-1:0] link_hit,
    output logic                 flooding,
    output logic                 cause_local,
    output logic [NUM_LINKS-1:0] cause_link
);
    logic                 trigger;
    logic                 recorded;
    logic [NUM_LINKS-1:0] first_hit;

    assign trigger   = local_fatal || (|link_hit);
    assign recorded  = cause_local || (|cause_link);
    // Isolate the lowest set bit so the lowest-numbered link wins.
    assign first_hit = link_hit & (~link_hit + NUM_LINKS'(1));

    // Enter the flood state on any trigger; there is no exit but reset.
    always_ff @(posedge clk) begin
        if (!por_n || !warm_rst_n) begin
            flooding <= 1'b0;
        end else if (trigger) begin
            flooding <= 1'b1;
        end
    end

    // Capture the cause of the first flood since power-on only.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause_local <= 1'b0;
            cause_link  <= '0;
        end else if (warm_rst_n && !flooding && !recorded && trigger) begin
            cause_local <= local_fatal;
            cause_link  <= first_hit;
        end
    end
endmodule

// File: rtl/flood_rst_req.sv
// Terminal-side reset request: one pulse of RST_HOLD cycles per flood episode.
// Cleared only by power-on reset so a warm reset cannot cut the pulse short.
// Assumes the enable is sampled only when the flood begins.
module flood_rst_req
    import flood_pkg::*;
#(
    parameter int RST_HOLD = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic flooding,
    input  logic cfg_rst_en,
    output logic sys_rst_req
);
    localparam int HW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
    localparam logic [HW-1:0] LAST = HW'(RST_HOLD - 1);

    rq_state_t     state;
    logic [HW-1:0] cnt;

    // Walk idle -> hold -> done, rearming once the flood is gone.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state <= RQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                RQ_IDLE: begin
                    cnt <= '0;
                    if (flooding && cfg_rst_en) state <= RQ_HOLD;
                end
                RQ_HOLD: begin
                    if (cnt == LAST) state <= RQ_DONE;
                    else             cnt   <= cnt + HW'(1);
                end
                RQ_DONE: begin
                    if (!flooding) state <= RQ_IDLE;
                end
                default: state <= RQ_IDLE;
            endcase
        end
    end

    assign sys_rst_req = (state == RQ_HOLD);
endmodule

// File: rtl/flood_guard.sv
// Top of the fatal error flood controller: per-link detectors, flood state,
// outgoing word select and terminal reset request.
// Assumes link i occupies bits [i*CW +: CW] of the packed link buses.
module flood_guard #(
    parameter int NUM_LINKS = 3,
    parameter int CW        = 16,
    parameter int FLOOD_RUN = 4,
    parameter int RST_HOLD  = 16
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    warm_rst_n,
    input  logic                    local_fatal,
    input  logic                    cfg_rst_en,
    input  logic [NUM_LINKS*CW-1:0] rx_word,
    input  logic [NUM_LINKS*CW-1:0] tx_data,
    output logic [NUM_LINKS*CW-1:0] tx_word,
    output logic                    flooding,
    output logic                    sys_rst_req,
    output logic                    cause_local,
    output logic [NUM_LINKS-1:0]    cause_link
);
    logic [NUM_LINKS-1:0] link_hit;

    // One detector and one output select per link.
    for (genvar gi = 0; gi < NUM_LINKS; gi++) begin : g_link
        flood_rx_detect #(.CW(CW), .FLOOD_RUN(FLOOD_RUN)) u_det (
            .clk        (clk),
            .por_n      (por_n),
            .warm_rst_n (warm_rst_n),
            .rx_word    (rx_word[gi*CW +: CW]),
            .hit        (link_hit[gi])
        );
        assign tx_word[gi*CW +: CW] = flooding ? {CW{1'b1}} : tx_data[gi*CW +: CW];
    end

    flood_ctrl #(.NUM_LINKS(NUM_LINKS)) u_ctrl (
        .clk         (clk),
        .por_n       (por_n),
        .warm_rst_n  (warm_rst_n),
        .local_fatal (local_fatal),
        .link_hit    (link_hit),
        .flooding    (flooding),
        .cause_local (cause_local),
        .cause_link  (cause_link)
    );

    flood_rst_req #(.RST_HOLD(RST_HOLD)) u_req (
        .clk         (clk),
        .por_n       (por_n),
        .flooding    (flooding),
        .cfg_rst_en  (cfg_rst_en),
        .sys_rst_req (sys_rst_req)
    );
endmodule

// File: rtl/flood_guard_chk.sv
// Property checker for flood_guard, attached by bind below.
// Assumes the top's default link layout.
module flood_guard_chk #(
    parameter int NUM_LINKS = 3,
    parameter int CW        = 16,
    parameter int RST_HOLD  = 16
) (
    input logic                    clk,
    input logic                    por_n,
    input logic                    warm_rst_n,
    input logic                    local_fatal,
    input logic [NUM_LINKS*CW-1:0] tx_word,
    input logic                    flooding,
    input logic                    sys_rst_req,
    input logic                    cause_local,
    input logic [NUM_LINKS-1:0]    cause_link
);
    logic [31:0] req_run;

    // Length of the current high stretch of the reset request.
    always_ff @(posedge clk) begin
        if (!por_n)           req_run <= '0;
        else if (sys_rst_req) req_run <= req_run + 32'd1;
        else                  req_run <= '0;
    end

    p_local_enters_r2: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        local_fatal |=> flooding);

    p_flood_words_r2: assert property (@(posedge clk) disable iff (!por_n)
        flooding |-> (tx_word == {NUM_LINKS*CW{1'b1}}));

    p_no_exit_r4: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        flooding |=> flooding);

    p_link_onehot_r5: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(cause_link));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
        (cause_local || (|cause_link)) |=> ($stable(cause_local) && $stable(cause_link)));

    p_req_after_flood_r7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_req) |-> $past(flooding));

    p_req_length_r7: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_req |-> (req_run < 32'(RST_HOLD)));
endmodule

bind flood_guard flood_guard_chk #(
    .NUM_LINKS (NUM_LINKS),
    .CW        (CW),
    .RST_HOLD  (RST_HOLD)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .warm_rst_n  (warm_rst_n),
    .local_fatal (local_fatal),
    .tx_word     (tx_word),
    .flooding    (flooding),
    .sys_rst_req (sys_rst_req),
    .cause_local (cause_local),
    .cause_link  (cause_link)
);

// File: tb/flood_guard_bench.sv
// Directed bench for flood_guard: inputs driven and outputs sampled on the
// falling edge, one task per scenario.
module flood_guard_bench;
    localparam int L    = 3;
    localparam int CW   = 16;
    localparam int RUN  = 4;
    localparam int HOLD = 16;
    localparam logic [CW-1:0] ONES = {CW{1'b1}};

    logic            clk = 1'b0;
    logic            por_n, warm_rst_n, local_fatal, cfg_rst_en;
    logic [L*CW-1:0] rx_word, tx_data, tx_word;
    logic            flooding, sys_rst_req, cause_local;
    logic [L-1:0]    cause_link;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    flood_guard #(.NUM_LINKS(L), .CW(CW), .FLOOD_RUN(RUN), .RST_HOLD(HOLD)) u_flood_guard (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .local_fatal(local_fatal),
        .cfg_rst_en(cfg_rst_en), .rx_word(rx_word), .tx_data(tx_data), .tx_word(tx_word),
        .flooding(flooding), .sys_rst_req(sys_rst_req), .cause_local(cause_local),
        .cause_link(cause_link)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_rx(input int link, input logic [CW-1:0] w);
        rx_word[link*CW +: CW] = w;
    endtask

    task automatic do_por();
        por_n = 1'b0; warm_rst_n = 1'b1; local_fatal = 1'b0;
        rx_word = '0;
        step(); step();
        por_n = 1'b1;
    endtask

    task automatic do_warm();
        warm_rst_n = 1'b0;
        step();
        warm_rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        tx_data = 48'h1234_5678_9abc;
        do_por();
        check(flooding == 1'b0, "R1 flooding", flooding, 0);
        check(sys_rst_req == 1'b0, "R1 sys_rst_req", sys_rst_req, 0);
        check(cause_local == 1'b0 && cause_link == '0, "R1 causes", {cause_local, cause_link}, 0);
        check(tx_word == tx_data, "R1 tx_word", tx_word, tx_data);
    endtask

    task automatic t_passthrough();
        for (int i = 0; i < 5; i++) begin
            tx_data = {16'(i * 3 + 1), 16'hA5A5 ^ 16'(i), 16'(i)};
            rx_word = {16'hFFFE, 16'(i), 16'h7FFF};
            step();
            check(tx_word == tx_data, "R10 passthrough", tx_word, tx_data);
        end
        check(flooding == 1'b0, "R10 no flood", flooding, 0);
    endtask

    task automatic t_short_run();
        for (int i = 0; i < RUN - 1; i++) begin set_rx(1, ONES); step(); end
        set_rx(1, 16'h0F0F); step();
        for (int i = 0; i < RUN - 1; i++) begin set_rx(1, ONES); step(); end
        set_rx(1, 16'h0000); step();
        check(flooding == 1'b0, "R3 broken run", flooding, 0);
    endtask

    task automatic t_link_flood_with_req();
        int first, cnt;
        cfg_rst_en = 1'b1;
        tx_data = 48'h1111_2222_3333;
        for (int i = 0; i < RUN - 1; i++) begin set_rx(2, ONES); step(); end
        check(flooding == 1'b0, "R3 before last word", flooding, 0);
        step();
        check(flooding == 1'b1, "R3 flood at last word", flooding, 1);
        check(tx_word == {L*CW{1'b1}}, "R2 flood words", tx_word, {L*CW{1'b1}});
        check(sys_rst_req == 1'b0, "R7 not same cycle", sys_rst_req, 0);
        check(cause_local == 1'b0 && cause_link == 3'b100, "R5 link cause",
              {cause_local, cause_link}, 4'b0100);
        rx_word = '0;
        first = -1; cnt = 0;
        for (int i = 1; i <= HOLD + 20; i++) begin
            step();
            if (sys_rst_req) begin cnt++; if (first < 0) first = i; end
        end
        check(first == 1, "R7 request start", first, 1);
        check(cnt == HOLD, "R7 request length", cnt, HOLD);
        check(flooding == 1'b1, "R4 stays flooding", flooding, 1);
        check(tx_word == {L*CW{1'b1}}, "R4 still flood words", tx_word, {L*CW{1'b1}});
    endtask

    task automatic t_warm_reset();
        do_warm();
        check(flooding == 1'b0, "R9 flooding cleared", flooding, 0);
        check(tx_word == tx_data, "R9 tx restored", tx_word, tx_data);
        check(cause_link == 3'b100 && cause_local == 1'b0, "R6 causes kept",
              {cause_local, cause_link}, 4'b0100);
        // Split a run across a warm reset: the partial count must be gone.
        for (int i = 0; i < RUN - 1; i++) begin set_rx(0, ONES); step(); end
        do_warm();
        for (int i = 0; i < RUN - 1; i++) begin set_rx(0, ONES); step(); end
        check(flooding == 1'b0, "R9 run count cleared", flooding, 0);
        rx_word = '0; step();
    endtask

    task automatic t_local_no_req();
        int cnt = 0;
        cfg_rst_en = 1'b0;
        local_fatal = 1'b1; step(); local_fatal = 1'b0;
        check(flooding == 1'b1, "R2 local flood", flooding, 1);
        check(cause_local == 1'b0 && cause_link == 3'b100, "R5 first cause kept",
              {cause_local, cause_link}, 4'b0100);
        for (int i = 0; i < 30; i++) begin step(); if (sys_rst_req) cnt++; end
        check(cnt == 0, "R8 no request", cnt, 0);
    endtask

    task automatic t_por_causes();
        do_por();
        check(cause_local == 1'b0 && cause_link == '0, "R6 por clears", {cause_local, cause_link}, 0);
        local_fatal = 1'b1; step(); local_fatal = 1'b0;
        check(cause_local == 1'b1 && cause_link == '0, "R5 local cause",
              {cause_local, cause_link}, 4'b1000);
        do_por();
        for (int i = 0; i < RUN; i++) begin set_rx(0, ONES); set_rx(2, ONES); step(); end
        check(cause_link == 3'b001 && cause_local == 1'b0, "R5 lowest link wins",
              {cause_local, cause_link}, 4'b0001);
    endtask

    initial begin
        bit done = 1'b0;
        por_n = 1'b0; warm_rst_n = 1'b1; local_fatal = 1'b0; cfg_rst_en = 1'b0;
        rx_word = '0; tx_data = '0;
        @(negedge clk);
        fork
            begin
                t_reset_state();
                t_passthrough();
                t_short_run();
                t_link_flood_with_req();
                t_warm_reset();
                t_local_no_req();
                t_por_causes();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++; fails++;
                    $display("FAIL watchdog actual=0 expected=1");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule